// File: doc/BRIEF.md
# Video Memory Transfer Sequencer

This block moves words into the video memory of a display controller without the processor doing the copying. It knows three kinds of job. The first pulls words from the host bus and writes them into video memory. The second writes one value to a run of video memory locations. The third reads video memory and writes the same words back at another place. The length, source and kind of job come from a set of byte-wide control registers. The destination start address and the step between destinations come from the surrounding controller.

A job starts on a single-cycle `start` pulse. The pulse is taken only when the enable bit from the mode register is set and no job is running. While a job runs, `busy` stays high. Host reads use a request/acknowledge handshake. Video memory reads return one word marked by `vm_rvalid`. Arbitration against other video memory users is left to the surrounding logic.

Top module: `vram_dma_engine`

## Requirements
- R1: After reset, `busy`, `vm_we`, `vm_re` and `host_req` are all 0.
- R2: Bits 7:6 of `src_hi` select the job kind when a job starts: 0x is a host copy, 10 is a fill and 11 is a video-memory copy.
- R3: A host copy reads word addresses {`src_hi`[6:0], `src_mid`, `src_lo`}, then that address plus 1, plus 2 and so on. The kind bit `src_hi`[6] is therefore the top address bit. `host_req` and `host_addr` hold steady until `host_ack`. The word returned with `host_ack` is the next word written to video memory.
- R4: A fill ignores the source registers and issues no reads. It waits for the first `fill_valid` word after the start pulse and writes that word to every destination of the job.
- R5: A video-memory copy reads from byte address {source word, 0}, where the source word is the low VADDR_W-1 bits of {`src_hi`[5:0], `src_mid`, `src_lo`}. It takes the word returned with `vm_rvalid` and writes it to the destination before it issues the next read.
- R6: The first write goes to `dest_addr`. Each later write goes to the previous write address plus `auto_inc`, modulo 2^VADDR_W.
- R7: The job writes exactly {`len_hi`, `len_lo`} words. A length of 0 means 65536 words.
- R8: A start pulse while `dma_en` is 0 is ignored: `busy` stays 0 and the memory ports stay quiet.
- R9: `busy` rises in the cycle after an accepted start and falls in the cycle after the last write.
- R10: The source pointer wraps within its own field: modulo 2^23 for a host copy and modulo 2^(VADDR_W-1) words for a video-memory copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Transfer enable bit from the mode register |
| start | input | 1 | Single-cycle request to begin a job |
| len_lo | input | 8 | Low byte of the word count |
| len_hi | input | 8 | High byte of the word count |
| src_lo | input | 8 | Low byte of the source word address |
| src_mid | input | 8 | Middle byte of the source word address |
| src_hi | input | 8 | Job kind in [7:6], high source bits in [5:0] |
| dest_addr | input | VADDR_W | First video memory byte address written |
| auto_inc | input | 8 | Step added to the destination after each write |
| fill_valid | input | 1 | A data-port word is present |
| fill_data | input | DATA_W | Data-port word |
| host_req | output | 1 | Host read request |
| host_addr | output | 23 | Host word address |
| host_ack | input | 1 | Host read completes |
| host_rdata | input | DATA_W | Host read data |
| vm_we | output | 1 | Video memory write strobe |
| vm_re | output | 1 | Video memory read strobe |
| vm_addr | output | VADDR_W | Video memory byte address |
| vm_wdata | output | DATA_W | Video memory write data |
| vm_rvalid | input | 1 | Video memory read data valid |
| vm_rdata | input | DATA_W | Video memory read data |
| busy | output | 1 | A job is in progress |

## Verification
The bench uses the default VADDR_W of 16 and DATA_W of 16. With these values the video-memory source field is only 15 bits wide, so a two-word copy starting at word 0x7FFF shows the source wrapping. A destination at 0xFFFE with a step of 4 shows the destination wrapping. A host copy from word 0x7FFFFF checks that the kind bit is used as the top address bit and that the address wraps past it. A length of 0 on a one-cycle-per-word fill gives the full 65536-word job in a cycle count the bench can afford.

// File: rtl/vram_dma_engine.sv
module vram_dma_engine #(
  parameter int VADDR_W = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_en,
  input  logic               start,
  input  logic [7:0]         len_lo,
  input  logic [7:0]         len_hi,
  input  logic [7:0]         src_lo,
  input  logic [7:0]         src_mid,
  input  logic [7:0]         src_hi,
  input  logic [VADDR_W-1:0] dest_addr,
  input  logic [7:0]         auto_inc,
  input  logic               fill_valid,
  input  logic [DATA_W-1:0]  fill_data,
  output logic               host_req,
  output logic [22:0]        host_addr,
  input  logic               host_ack,
  input  logic [DATA_W-1:0]  host_rdata,
  output logic               vm_we,
  output logic               vm_re,
  output logic [VADDR_W-1:0] vm_addr,
  output logic [DATA_W-1:0]  vm_wdata,
  input  logic               vm_rvalid,
  input  logic [DATA_W-1:0]  vm_rdata,
  output logic               busy
);
  localparam int LEN_W  = 16;
  localparam int CNT_W  = LEN_W + 1;
  localparam int HSRC_W = 23;
  localparam int VSRC_W = VADDR_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_FILLW, S_HREQ, S_VRD, S_VWAIT, S_WR} state_t;
  typedef enum logic [1:0] {K_HOST, K_FILL, K_COPY} kind_t;

  state_t             state;
  kind_t              kind;
  logic [CNT_W-1:0]   remain;
  logic [VADDR_W-1:0] dest;
  logic [HSRC_W-1:0]  src;
  logic [DATA_W-1:0]  word;
  logic [LEN_W-1:0]   len;

  assign len = {len_hi, len_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind   <= K_HOST;
      remain <= '0;
      dest   <= '0;
      src    <= '0;
      word   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start && dma_en) begin
          remain <= (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};
          dest   <= dest_addr;
          if (!src_hi[7]) begin
            kind  <= K_HOST;
            src   <= {src_hi[6:0], src_mid, src_lo};
            state <= S_HREQ;
          end else if (!src_hi[6]) begin
            kind  <= K_FILL;
            state <= S_FILLW;
          end else begin
            kind  <= K_COPY;
            src   <= {1'b0, src_hi[5:0], src_mid, src_lo};
            state <= S_VRD;
          end
        end
        S_FILLW: if (fill_valid) begin
          word  <= fill_data;
          state <= S_WR;
        end
        S_HREQ: if (host_ack) begin
          word  <= host_rdata;
          src   <= src + 1'b1;
          state <= S_WR;
        end
        S_VRD: state <= S_VWAIT;
        S_VWAIT: if (vm_rvalid) begin
          word  <= vm_rdata;
          src   <= src + 1'b1;
          state <= S_WR;
        end
        S_WR: begin
          dest   <= dest + VADDR_W'(auto_inc);
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= S_IDLE;
          else if (kind == K_HOST) state <= S_HREQ;
          else if (kind == K_COPY) state <= S_VRD;
          else                     state <= S_WR;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign host_req  = (state == S_HREQ);
  assign host_addr = src;
  assign vm_re     = (state == S_VRD);
  assign vm_we     = (state == S_WR);
  assign vm_addr   = vm_re ? {src[VSRC_W-1:0], 1'b0} : dest;
  assign vm_wdata  = word;

  p_ignore_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !dma_en) |=> !busy);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && dma_en) |=> busy);

  p_end_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(vm_we));

  p_host_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_ack) |=> (host_req && $stable(host_addr)));

  p_fill_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vm_we && $past(vm_we)) |-> $stable(vm_wdata));

  p_stride_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vm_we && $past(vm_we) && $stable(auto_inc)) |-> (vm_addr == $past(vm_addr) + VADDR_W'(auto_inc)));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vm_we, vm_re, host_req}));
endmodule

// File: tb/tb_vram_dma_engine.sv
module tb_vram_dma_engine;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        dma_en = 0, start = 0;
  logic [7:0]  len_lo = 0, len_hi = 0, src_lo = 0, src_mid = 0, src_hi = 0, auto_inc = 0;
  logic [15:0] dest_addr = 0, fill_data = 0, host_rdata = 0, vm_rdata = 0;
  logic        fill_valid = 0, host_ack = 0, vm_rvalid = 0;
  logic        host_req, vm_we, vm_re, busy;
  logic [22:0] host_addr;
  logic [15:0] vm_addr, vm_wdata;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vram_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .start(start),
    .len_lo(len_lo), .len_hi(len_hi), .src_lo(src_lo), .src_mid(src_mid), .src_hi(src_hi),
    .dest_addr(dest_addr), .auto_inc(auto_inc), .fill_valid(fill_valid), .fill_data(fill_data),
    .host_req(host_req), .host_addr(host_addr), .host_ack(host_ack), .host_rdata(host_rdata),
    .vm_we(vm_we), .vm_re(vm_re), .vm_addr(vm_addr), .vm_wdata(vm_wdata),
    .vm_rvalid(vm_rvalid), .vm_rdata(vm_rdata), .busy(busy)
  );

  // vector: src_hi, src_mid, src_lo, len_hi, len_lo, dest[15:0], inc, fill[15:0]
  localparam logic [79:0] VEC [7] = '{
    {8'h00, 8'h12, 8'h34, 8'h00, 8'h05, 16'h1000, 8'h02, 16'h0000},
    {8'h7F, 8'hFF, 8'hFF, 8'h00, 8'h03, 16'h2000, 8'h02, 16'h0000},
    {8'hAA, 8'h55, 8'h66, 8'h00, 8'h04, 16'h0400, 8'h03, 16'hBEEF},
    {8'h80, 8'h00, 8'h00, 8'h00, 8'h03, 16'hFFFE, 8'h04, 16'h1234},
    {8'hC0, 8'h01, 8'h00, 8'h00, 8'h04, 16'h8000, 8'h02, 16'h0000},
    {8'hC0, 8'h7F, 8'hFF, 8'h00, 8'h02, 16'h4000, 8'h80, 16'h0000},
    {8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 16'h0000, 8'h02, 16'h0000}
  };

  function automatic logic [15:0] hmem(input logic [22:0] a);
    return a[15:0] ^ 16'h5A3C ^ {9'b0, a[22:16]};
  endfunction

  function automatic logic [15:0] vmem(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h0F0F;
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_job(input logic [79:0] v);
    logic [1:0]  k;
    logic [22:0] hs;
    logic [14:0] vs;
    logic [15:0] fillw;
    int          n, wr_k, rd_k, cyc;
    logic        pend;
    logic [15:0] paddr, exp_d;
    k     = v[79] ? (v[78] ? 2'd2 : 2'd1) : 2'd0;
    hs    = {v[78:72], v[71:64], v[63:56]};
    vs    = {v[70:64], v[63:56]};
    fillw = v[15:0];
    n     = (v[55:40] == 16'h0) ? 65536 : int'(v[55:40]);
    @(negedge clk);
    src_hi = v[79:72]; src_mid = v[71:64]; src_lo = v[63:56];
    len_hi = v[55:48]; len_lo = v[47:40]; dest_addr = v[39:24]; auto_inc = v[23:16];
    fill_data = 16'hDEAD; fill_valid = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    wr_k = 0; rd_k = 0; pend = 0; paddr = 0; cyc = 0;
    forever begin
      host_ack = 0; vm_rvalid = 0; fill_valid = 0;
      if (cyc == 0 && k == 2'd1) begin fill_valid = 1; fill_data = fillw; end
      if (pend) begin vm_rvalid = 1; vm_rdata = vmem(paddr); pend = 0; end
      if (vm_re) begin
        chk(k == 2'd2 && vm_addr == {vs + 15'(rd_k), 1'b0}, "R5 R10 copy read address", vm_addr, {vs + 15'(rd_k), 1'b0});
        pend = 1; paddr = vm_addr; rd_k++;
      end
      if (host_req) begin
        chk(k == 2'd0 && host_addr == hs + 23'(rd_k), "R3 R10 host read address", host_addr, hs + 23'(rd_k));
        host_ack = 1; host_rdata = hmem(host_addr); rd_k++;
      end
      if (vm_we) begin
        case (k)
          2'd0: exp_d = hmem(hs + 23'(wr_k));
          2'd1: exp_d = fillw;
          default: exp_d = vmem({vs + 15'(wr_k), 1'b0});
        endcase
        chk(vm_addr == v[39:24] + 16'(wr_k) * 16'(v[23:16]), "R6 write address", vm_addr, v[39:24] + 16'(wr_k) * 16'(v[23:16]));
        chk(vm_wdata == exp_d, "R2 R4 write data", vm_wdata, exp_d);
        wr_k++;
      end
      if (!busy) break;
      cyc++;
      if (cyc > 150000) break;
      @(negedge clk);
    end
    chk(wr_k == n, "R7 R9 word count", wr_k, n);
    if (k == 2'd1) chk(rd_k == 0, "R4 no reads on fill", rd_k, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, vm_we, vm_re, host_req} == 4'b0, "R1 reset outputs", {busy, vm_we, vm_re, host_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, vm_we, vm_re, host_req} == 4'b0, "R1 idle after reset", {busy, vm_we, vm_re, host_req}, 0);

    // R8: enable bit low
    src_hi = 8'h00; len_lo = 8'h04; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 8; i++) begin
      chk({busy, vm_we, vm_re, host_req} == 4'b0, "R8 start ignored when disabled", {busy, vm_we, vm_re, host_req}, 0);
      @(negedge clk);
    end

    dma_en = 1;
    for (int i = 0; i < 7; i++) run_job(VEC[i]);

    // R7: zero length means 65536 words
    run_job({8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h02, 16'hA5A5});

    @(negedge clk);
    chk(busy == 1'b0, "R9 idle at end", busy, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule